// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading a tree of page tables held in memory. Each table holds 512 entries of 64 bits. Every level of the tree is selected by a 9-bit slice of the virtual address, and the lowest 12 address bits are the byte offset inside a 4 KiB page. A mode input chooses between a four-level tree and a five-level tree. The mode is captured when the request is accepted. The same input sets which upper address bits must be sign copies.

A client presents a request made of an address, a root table base and the mode bit. The block first checks that the address is canonical for the chosen mode. A non-canonical address is rejected without touching memory. Otherwise the block issues one read per level through a valid/ready request port with a valid-only response port, and never has more than one read in flight. The walk ends on a leaf entry, which yields the physical page frame, or on an entry whose present bit is clear. The result comes back with a one-cycle done pulse.

The controller has four states. IDLE waits for and accepts requests. ISSUE holds a table read on the memory port until it is taken. WAIT waits for the read data. DONE presents the result. The transitions are as follows. IDLE goes to ISSUE when the address is canonical and to DONE when it is not. ISSUE goes to WAIT when the read is taken. WAIT goes back to ISSUE when a present entry above the leaf arrives. WAIT goes to DONE on the leaf or on a not-present entry. DONE always returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: In four-level mode, an address whose bits 63..48 are not all equal to bit 47 is rejected. The block pulses `done` with `done_fault` = 1 (non-canonical) and `done_level` = 0, and issues no memory read.
- R3: In five-level mode, bits 63..57 must all equal bit 56. If they do not, the block reports the same fault as in R2 and issues no read. An address is judged only against the rule of its own mode.
- R4: A four-level walk issues exactly 4 reads, indexed in turn by address bits 47..39, 38..30, 29..21 and 20..12. Each read address is the current table base plus the index times 8.
- R5: A five-level walk issues exactly 5 reads. The first read is indexed by bits 56..48, and the remaining four follow R4.
- R6: The first table base is `req_root` bits 51..12 with the low 12 bits zero. Each later base is bits 51..12 of the entry just read, with the low 12 bits zero. Entry bits 63..52 and 11..1 are ignored.
- R7: On success, `done_fault` = 0, `done_level` = 0, and `done_pa` = {12 zero bits, leaf entry bits 51..12, address bits 11..0}.
- R8: An entry with bit 0 (present) clear stops the walk with no further reads. The block reports `done_fault` = 2 (not present) and `done_level` = the level of that entry. Levels are numbered 5 (top of a five-level tree) or 4 (top of a four-level tree) down to 1 (leaf table).
- R9: Only one read is outstanding at a time. A read request stays asserted with a stable address until `mem_req_ready`.
- R10: `req_ready` is high only in IDLE, and `done` lasts exactly one cycle.
- R11: The mode is sampled at request acceptance. Changing `req_five` during a walk does not change the number of reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root table base (bits 51..12 used) |
| req_five | input | 1 | 1 = five-level mode, 0 = four-level mode |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle result pulse |
| done_fault | output | 2 | 0 ok, 1 non-canonical, 2 not present |
| done_level | output | 3 | Level of a not-present fault, else 0 |
| done_pa | output | 64 | Translated physical address |

## Verification
The hardest cases to reach from the ports are a not-present entry deep inside a walk and a mode change in the middle of a walk. Both need memory contents that the walk has to follow correctly before the corner case appears. The bench keeps a sparse memory model and builds real table chains into it for each address. It then clears the present bit of the entry at a chosen level, on a private root, so that faults at the top, middle and leaf levels can be reached. For the mode case, it flips `req_five` in the cycle after acceptance, in both directions. The memory's ready and response latency vary from cycle to cycle, so every read meets both back-pressure and waiting.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_NONCANON   = 2'd1,
        FLT_NOTPRESENT = 2'd2
    } pw_fault_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } pw_state_e;

endpackage

// File: rtl/pw_canon.sv
module pw_canon #(
    parameter int VA_W     = 64,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 9,
    parameter int MAX_LVLS = 5
) (
    input  logic [VA_W-1:0] va,
    input  logic            five,
    output logic            ok
);
    logic [1:0] mode_ok;

    // mode 0: MAX_LVLS-1 levels, mode 1: MAX_LVLS levels
    for (genvar m = 0; m < 2; m++) begin : g_mode
        localparam int TOP = OFF_W + IDX_W * (MAX_LVLS - 1 + m) - 1;
        assign mode_ok[m] = (&va[VA_W-1:TOP]) | ~(|va[VA_W-1:TOP]);
    end

    assign ok = mode_ok[five];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int VA_W     = 64,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 9,
    parameter int MAX_LVLS = 5,
    parameter int LVL_W    = 3
) (
    input  logic [VA_W-1:0]  va,
    input  logic [VA_W-1:0]  table_base,
    input  logic [LVL_W-1:0] lvl,
    output logic [VA_W-1:0]  entry_addr
);
    localparam int ENT_SHIFT = 3;   // 8-byte entries
    localparam int N_SLOTS   = 2 ** LVL_W;

    logic [IDX_W-1:0] idx_by_lvl [N_SLOTS];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_idx
        if (g >= 1 && g <= MAX_LVLS) begin : g_used
            assign idx_by_lvl[g] = va[OFF_W + IDX_W * (g - 1) +: IDX_W];
        end else begin : g_unused
            assign idx_by_lvl[g] = '0;
        end
    end

    assign idx        = idx_by_lvl[lvl];
    assign entry_addr = table_base
                      + {{(VA_W - IDX_W - ENT_SHIFT){1'b0}}, idx, {ENT_SHIFT{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 9,
    parameter int FRAME_HI = 51,
    parameter int MAX_LVLS = 5,
    parameter int LVL_W    = $clog2(MAX_LVLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [VA_W-1:0]  req_root,
    input  logic             req_five,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [VA_W-1:0]  mem_rsp_data,
    output logic             done,
    output logic [1:0]       done_fault,
    output logic [LVL_W-1:0] done_level,
    output logic [VA_W-1:0]  done_pa
);
    localparam int HI_PAD = VA_W - FRAME_HI - 1;
    localparam logic [LVL_W-1:0] LVL_TOP5 = LVL_W'(MAX_LVLS);
    localparam logic [LVL_W-1:0] LVL_TOP4 = LVL_W'(MAX_LVLS - 1);
    localparam logic [LVL_W-1:0] LVL_LEAF = LVL_W'(1);

    pw_state_e        state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [VA_W-1:0]  va_q, base_q;
    logic [VA_W-1:0]  res_pa_q;
    pw_fault_e        res_fault_q;
    logic [LVL_W-1:0] res_lvl_q;

    logic             canon_ok;
    logic [VA_W-1:0]  entry_addr;
    logic             accept, rsp_here, rsp_present, at_leaf;
    logic [VA_W-1:0]  root_base, next_base, leaf_pa;

    pw_canon #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .MAX_LVLS(MAX_LVLS)
    ) u_canon (
        .va   (req_va),
        .five (req_five),
        .ok   (canon_ok)
    );

    pw_entry_addr #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .MAX_LVLS(MAX_LVLS), .LVL_W(LVL_W)
    ) u_eaddr (
        .va         (va_q),
        .table_base (base_q),
        .lvl        (lvl_q),
        .entry_addr (entry_addr)
    );

    assign accept      = (state_q == S_IDLE) && req_valid;
    assign rsp_here    = (state_q == S_WAIT) && mem_rsp_valid;
    assign rsp_present = mem_rsp_data[0];
    assign at_leaf     = (lvl_q == LVL_LEAF);
    assign root_base   = {{HI_PAD{1'b0}}, req_root[FRAME_HI:OFF_W], {OFF_W{1'b0}}};
    assign next_base   = {{HI_PAD{1'b0}}, mem_rsp_data[FRAME_HI:OFF_W], {OFF_W{1'b0}}};
    assign leaf_pa     = {{HI_PAD{1'b0}}, mem_rsp_data[FRAME_HI:OFF_W], va_q[OFF_W-1:0]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = canon_ok ? S_ISSUE : S_DONE;
            S_ISSUE: if (mem_req_ready) state_d = S_WAIT;
            S_WAIT:  if (mem_rsp_valid)
                         state_d = (!rsp_present || at_leaf) ? S_DONE : S_ISSUE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q       <= '0;
            va_q        <= '0;
            base_q      <= '0;
            res_pa_q    <= '0;
            res_fault_q <= FLT_NONE;
            res_lvl_q   <= '0;
        end else if (accept) begin
            va_q        <= req_va;
            base_q      <= root_base;
            lvl_q       <= req_five ? LVL_TOP5 : LVL_TOP4;
            res_pa_q    <= '0;
            res_lvl_q   <= '0;
            res_fault_q <= canon_ok ? FLT_NONE : FLT_NONCANON;
        end else if (rsp_here) begin
            if (!rsp_present) begin
                res_fault_q <= FLT_NOTPRESENT;
                res_lvl_q   <= lvl_q;
            end else if (at_leaf) begin
                res_pa_q    <= leaf_pa;
            end else begin
                base_q      <= next_base;
                lvl_q       <= lvl_q - LVL_LEAF;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_ISSUE);
        mem_req_addr  = entry_addr;
        done          = (state_q == S_DONE);
        done_fault    = res_fault_q;
        done_level    = res_lvl_q;
        done_pa       = res_pa_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int VA_W  = 64,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_va,
    input logic             req_five,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [VA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [VA_W-1:0]  mem_rsp_data,
    input logic             done,
    input logic [1:0]       done_fault,
    input logic [VA_W-1:0]  done_pa
);
    logic            pend;
    logic [11:0]     off_lat;
    logic            acc;
    logic            va_canon;

    assign acc      = req_valid && req_ready;
    assign va_canon = req_five
                    ? ((&req_va[63:56]) || !(|req_va[63:56]))
                    : ((&req_va[63:47]) || !(|req_va[63:47]));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            off_lat <= '0;
        end else begin
            if (acc) off_lat <= req_va[11:0];
            if (mem_req_valid && mem_req_ready) pend <= 1'b1;
            else if (mem_rsp_valid)             pend <= 1'b0;
        end
    end

    AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !va_canon |=> done && done_fault == 2'd1 && !mem_req_valid); // R2

    AST_NONCANON_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_five && va_canon |=> !done); // R3

    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'd0); // R4

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault == 2'd0 |-> done_pa[11:0] == off_lat); // R7

    AST_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        pend && mem_rsp_valid && !mem_rsp_data[0] |=> done && done_fault == 2'd2); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !mem_req_valid); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend || mem_req_valid || done) |-> !req_ready); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_five      (req_five),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .done_fault    (done_fault),
    .done_pa       (done_pa)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [63:0] req_root = '0;
    logic        req_five = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [1:0]  done_fault;
    logic [2:0]  done_level;
    logic [63:0] done_pa;

    always #2.5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_root(req_root), .req_five(req_five),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_level(done_level),
        .done_pa(done_pa)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // sparse memory model
    logic [63:0] mem [logic [63:0]];
    logic [39:0] next_frame = 40'h100;
    logic [63:0] last_ea [1:5];

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    int          cyc = 0;
    int          rd_count = 0;
    int          pend_cnt = 0;
    logic [63:0] rsp_hold = '0;

    always @(posedge clk) begin
        cyc           <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 1;
        mem_rsp_valid <= 1'b0;
        if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rsp_hold;
            end
        end else if (rst_n && mem_req_valid && mem_req_ready) begin
            rd_count <= rd_count + 1;
            rsp_hold <= rd(mem_req_addr);
            pend_cnt <= 1 + (cyc % 2);
        end
    end

    function automatic logic [63:0] new_root();
        logic [63:0] r;
        r = {12'hABC, next_frame, 12'h5A5};   // junk outside 51..12 (R6)
        next_frame++;
        return r;
    endfunction

    // build a table chain for va; leaf and inner entries carry junk bits (R6)
    task automatic map_va(input logic [63:0] root, input logic [63:0] va,
                          input bit five, input logic [39:0] leaf);
        logic [63:0] base, a;
        logic [8:0]  idx;
        base = {12'h0, root[51:12], 12'h0};
        for (int l = (five ? 5 : 4); l >= 1; l--) begin
            idx = va[12 + 9 * (l - 1) +: 9];
            a = base + {52'h0, idx, 3'b000};
            last_ea[l] = a;
            if (l == 1) begin
                mem[a] = {12'h801, leaf, 12'hFE1};
            end else begin
                if (rd(a) == 64'h0) begin
                    mem[a] = {12'hC00, next_frame, 12'h0A3};
                    next_frame++;
                end
                base = {12'h0, rd(a)[51:12], 12'h0};
            end
        end
    endtask

    typedef struct {
        logic [63:0] pa;
        logic [1:0]  fault;
        logic [2:0]  lvl;
        int          reads;
        int          start;
        string       tag;
    } exp_t;

    exp_t q[$];

    task automatic run_req(input logic [63:0] va, input logic [63:0] root,
                           input bit five, input bit flip,
                           input logic [1:0] fault, input logic [63:0] pa,
                           input logic [2:0] lvl, input int reads,
                           input string tag);
        exp_t e;
        e.pa = pa; e.fault = fault; e.lvl = lvl; e.reads = reads;
        e.start = rd_count; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_va = va; req_root = root; req_five = five; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) req_five = ~five;
        while (!req_ready) @(negedge clk);
    endtask

    // monitor: compare results as they appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 64'h1, 64'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(done_fault == e.fault, e.tag, "fault", 64'(done_fault), 64'(e.fault));
                chk(done_level == e.lvl, e.tag, "level", 64'(done_level), 64'(e.lvl));
                chk((rd_count - e.start) == e.reads, e.tag, "reads",
                    64'(rd_count - e.start), 64'(e.reads));
                if (e.fault == 2'd0)
                    chk(done_pa == e.pa, e.tag, "pa", done_pa, e.pa);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 64'h0, 64'h1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] r4, r5, rx;
        logic [63:0] va;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'h1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'h0);
        chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'h1);

        r4 = new_root();
        r5 = new_root();

        // R4 R6 R7: four-level walks, low and high canonical halves
        va = 64'h0000_1234_5678_9ABC;
        map_va(r4, va, 1'b0, 40'h11_2233_4455);
        run_req(va, r4, 1'b0, 1'b0, 2'd0, {12'h0, 40'h11_2233_4455, va[11:0]}, 3'd0, 4, "R4");
        va = 64'hFFFF_8000_1234_5FFF;
        map_va(r4, va, 1'b0, 40'hAB_CDEF_0123);
        run_req(va, r4, 1'b0, 1'b0, 2'd0, {12'h0, 40'hAB_CDEF_0123, va[11:0]}, 3'd0, 4, "R7");
        va = 64'h0000_7FFF_FFFF_FFFF;
        map_va(r4, va, 1'b0, 40'hFF_FFFF_FFFF);
        run_req(va, r4, 1'b0, 1'b0, 2'd0, {12'h0, 40'hFF_FFFF_FFFF, va[11:0]}, 3'd0, 4, "R6");

        // R5: five-level walks, both halves
        va = 64'h00AA_CDEF_0123_4567;
        map_va(r5, va, 1'b1, 40'h01_0203_0405);
        run_req(va, r5, 1'b1, 1'b0, 2'd0, {12'h0, 40'h01_0203_0405, va[11:0]}, 3'd0, 5, "R5");
        va = 64'hFF01_2345_6789_A000;
        map_va(r5, va, 1'b1, 40'h7E_5A5A_0F0F);
        run_req(va, r5, 1'b1, 1'b0, 2'd0, {12'h0, 40'h7E_5A5A_0F0F, va[11:0]}, 3'd0, 5, "R5");

        // R2: non-canonical in four-level mode (valid in five-level mode)
        run_req(64'h00AA_CDEF_0123_4567, r4, 1'b0, 1'b0, 2'd1, 64'h0, 3'd0, 0, "R2");
        run_req(64'h0000_8000_0000_0000, r4, 1'b0, 1'b0, 2'd1, 64'h0, 3'd0, 0, "R2");
        // R3: non-canonical in five-level mode
        run_req(64'h0100_0000_0000_0000, r5, 1'b1, 1'b0, 2'd1, 64'h0, 3'd0, 0, "R3");
        run_req(64'h7FFF_0000_0000_0000, r5, 1'b1, 1'b0, 2'd1, 64'h0, 3'd0, 0, "R3");
        // R3: canonical in five-level mode though not in four-level mode
        va = 64'h0000_8000_0000_1000;
        map_va(r5, va, 1'b1, 40'h33_3333_3333);
        run_req(va, r5, 1'b1, 1'b0, 2'd0, {12'h0, 40'h33_3333_3333, va[11:0]}, 3'd0, 5, "R3");

        // R8: not-present entries at several levels, each on a private root
        va = 64'h0012_3456_789A_B000;
        rx = new_root(); map_va(rx, va, 1'b1, 40'h1);
        mem[last_ea[5]] = 64'h000F_FFFF_FFFF_F0FE;
        run_req(va, rx, 1'b1, 1'b0, 2'd2, 64'h0, 3'd5, 1, "R8");
        rx = new_root(); map_va(rx, va, 1'b1, 40'h2);
        mem[last_ea[3]] = 64'h000F_FFFF_FFFF_F0FE;
        run_req(va, rx, 1'b1, 1'b0, 2'd2, 64'h0, 3'd3, 3, "R8");
        va = 64'h0000_4321_8765_C123;
        rx = new_root(); map_va(rx, va, 1'b0, 40'h3);
        mem[last_ea[1]] = 64'h8000_0000_0000_0FFE;
        run_req(va, rx, 1'b0, 1'b0, 2'd2, 64'h0, 3'd1, 4, "R8");
        rx = new_root(); map_va(rx, va, 1'b0, 40'h4);
        mem[last_ea[4]] = 64'h0;
        run_req(va, rx, 1'b0, 1'b0, 2'd2, 64'h0, 3'd4, 1, "R8");

        // R11: mode flipped right after acceptance, both directions
        va = 64'h00AA_CDEF_0123_4567;
        run_req(va, r5, 1'b1, 1'b1, 2'd0, {12'h0, 40'h01_0203_0405, va[11:0]}, 3'd0, 5, "R11");
        va = 64'h0000_1234_5678_9ABC;
        run_req(va, r4, 1'b0, 1'b1, 2'd0, {12'h0, 40'h11_2233_4455, va[11:0]}, 3'd0, 4, "R11");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R10", "results outstanding", 64'(q.size()), 64'h0);
        chk(req_ready == 1'b1, "R10", "idle ready", 64'(req_ready), 64'h1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule